// File: doc/BRIEF.md
# Dual-Mode PHY Transmit Serializer

This block sits between a MAC byte stream and the transmit pins of an external PHY. A static mode input selects one of two line formats. In nibble mode each byte leaves as two 4-bit units on the four data lines. In serial mode each byte leaves as eight single bits on data line 0. A frame is framed on the line by an active-high enable that is high exactly while frame units are on the data lines. All logic runs from the transmit clock that the PHY supplies. Nibble mode launches on the rising edge. Serial mode launches on the falling edge.

The MAC side is a valid/ready byte stream with start and end markers. The handshake completes on a rising edge when both valid and ready are high. Back-pressure rules:
- Ready is high while the line is idle.
- During a frame, ready is high only during the final unit of a byte that is not the frame's last byte. The next byte is therefore taken exactly when the line needs it.
- The MAC may hold valid with its data stable for as long as ready is low. Nothing is lost or repeated.
- If the MAC has no byte at a byte boundary, the frame is cut short.

The mode input may only change while reset is asserted.

Top module: `mii_tx_if`

## Requirements
- R1: With `ser_mode` low, `tx_en` and `tx_d` change only on rising edges of `tx_clk`. Each byte is sent as two units on `tx_d[3:0]`: bits 3:0 first, then bits 7:4.
- R2: With `ser_mode` high, `tx_en` and `tx_d` change only on falling edges of `tx_clk`. Each byte is sent as eight units on `tx_d[0]`, bit 0 first. `tx_d[3:1]` are always 0.
- R3: `tx_en` is high exactly while a frame unit is on `tx_d`. While `tx_en` is low, `tx_d` is 0.
- R4: `in_ready` is high whenever the line is idle. During a frame it is high only in the last unit of a byte that does not carry `in_eof`. With `in_valid` held, the units of a frame follow each other with no gap and `tx_en` stays high throughout.
- R5: While the line is idle, a byte presented without `in_sof` is accepted and discarded. It produces no output and `tx_en` stays low. A byte with `in_sof` starts a frame; its first unit appears in the next launch.
- R6: `tx_en` falls at the launch edge right after the last unit of the byte marked `in_eof`. `in_ready` stays low during that byte, so the next frame cannot start before `tx_en` has been low for at least one cycle.
- R7: If no byte is offered at a byte boundary inside a frame, `tx_en` falls at the next launch edge and the frame is abandoned. Later bytes without `in_sof` are then discarded under R5.
- R8: After reset, `tx_en` is 0, `tx_d` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock supplied by the PHY |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 1 | 0 = nibble mode, 1 = single-bit serial mode; static outside reset |
| in_valid | input | 1 | MAC byte valid |
| in_ready | output | 1 | Block can take a byte on this rising edge |
| in_data | input | 8 | MAC byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| tx_en | output | 1 | Transmit enable to the PHY, active high |
| tx_d | output | 4 | Transmit data to the PHY |

## Verification
The bench sends random frames in both modes, with random bytes and lengths, and records every unit on the line. It compares the record against unit orders computed from the bytes. A swapped nibble order or an MSB-first shift then shows up as wrong line data. A ready that rises one unit too early or too late shows up as a duplicated byte, a lost byte, a split enable or an extra unit. Directed cases cover several faults:
- the launch edge in each mode: a serial output that moves on the rising edge is caught half a cycle early;
- a one-byte frame;
- a byte without a start marker while idle, which must not raise enable;
- a MAC underrun in mid-frame, which must end the enable instead of repeating stale data.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int unsigned LANES = 4;

  typedef struct packed {
    logic             en;
    logic [LANES-1:0] d;
  } phy_word_t;
endpackage

// File: rtl/mtx_shifter.sv
module mtx_shifter
  import mtx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output phy_word_t         word_q
);
  localparam int unsigned MII_UNITS = DATA_W / NIB_W;
  localparam int unsigned SER_UNITS = DATA_W;
  localparam int unsigned REM_W     = $clog2(SER_UNITS);

  logic [DATA_W-1:0] shreg;
  logic [REM_W-1:0]  rem;
  logic              last_q;
  logic              take;

  function automatic logic [LANES-1:0] unit_of(input logic [DATA_W-1:0] b, input logic s);
    logic [LANES-1:0] u;
    u = '0;
    if (s) u[0] = b[0];
    else   u[NIB_W-1:0] = b[NIB_W-1:0];
    return u;
  endfunction

  function automatic logic [DATA_W-1:0] rest_of(input logic [DATA_W-1:0] b, input logic s);
    return s ? (b >> 1) : (b >> NIB_W);
  endfunction

  assign in_ready = !word_q.en || (rem == '0 && !last_q);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      shreg  <= '0;
      rem    <= '0;
      last_q <= 1'b0;
    end else if (take && (word_q.en || in_sof)) begin
      word_q.en <= 1'b1;
      word_q.d  <= unit_of(in_data, ser);
      shreg     <= rest_of(in_data, ser);
      rem       <= ser ? REM_W'(SER_UNITS - 1) : REM_W'(MII_UNITS - 1);
      last_q    <= in_eof;
    end else if (word_q.en && rem != '0) begin
      word_q.d <= unit_of(shreg, ser);
      shreg    <= rest_of(shreg, ser);
      rem      <= rem - 1'b1;
    end else if (word_q.en) begin
      word_q <= '0;
    end
  end
endmodule

// File: rtl/mtx_launch.sv
module mtx_launch
  import mtx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ser,
  input  phy_word_t rise_w,
  output phy_word_t line_w
);
  phy_word_t fall_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= rise_w;
  end

  assign line_w = ser ? fall_q : rise_w;
endmodule

// File: rtl/mii_tx_if.sv
module mii_tx_if
  import mtx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              tx_clk,
  input  logic              rst_n,
  input  logic              ser_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              tx_en,
  output logic [LANES-1:0]  tx_d
);
  phy_word_t rise_w;
  phy_word_t line_w;

  mtx_shifter #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_shift (
    .clk      (tx_clk),
    .rst_n    (rst_n),
    .ser      (ser_mode),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_ready (in_ready),
    .word_q   (rise_w)
  );

  mtx_launch u_launch (
    .clk    (tx_clk),
    .rst_n  (rst_n),
    .ser    (ser_mode),
    .rise_w (rise_w),
    .line_w (line_w)
  );

  assign tx_en = line_w.en;
  assign tx_d  = line_w.d;
endmodule

// File: rtl/mtx_checker.sv
module mtx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ser_mode,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sof,
  input logic       in_eof,
  input logic       tx_en,
  input logic [3:0] tx_d
);
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> tx_d == 4'd0);

  assert_ser_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_mode |-> tx_d[3:1] == 3'd0);

  assert_idle_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && !tx_en) |-> in_ready);

  assert_start_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && !tx_en && in_valid && in_ready && !in_sof) |=> !tx_en);

  assert_eof_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && in_valid && in_ready && in_eof && (tx_en || in_sof))
      |=> (tx_en && !in_ready) ##1 (tx_en && !in_ready) ##1 !tx_en);
endmodule

bind mii_tx_if mtx_checker u_chk (
  .clk      (tx_clk),
  .rst_n    (rst_n),
  .ser_mode (ser_mode),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_sof   (in_sof),
  .in_eof   (in_eof),
  .tx_en    (tx_en),
  .tx_d     (tx_d)
);

// File: tb/tb_mii_tx_if.sv
module tb_mii_tx_if;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'd0;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       tx_en;
  logic [3:0] tx_d;

  int errors = 0;
  int checks = 0;

  int cap [0:1023];
  int cap_n = 0;
  int segs = 0;
  int rdy_hi = 0;
  int stray = 0;
  logic prev_en = 1'b0;
  logic [7:0] fb [0:31];

  always #(PERIOD/2) clk = ~clk;

  mii_tx_if dut (
    .tx_clk(clk), .rst_n(rst_n), .ser_mode(ser_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .tx_en(tx_en), .tx_d(tx_d)
  );

  always begin
    @(negedge clk);
    #3;
    if (tx_en) begin
      if (!prev_en) segs++;
      if (cap_n < 1024) cap[cap_n] = int'(tx_d);
      cap_n++;
      if (in_ready) rdy_hi++;
    end else if (tx_d != 4'd0) stray++;
    if (ser_mode && tx_d[3:1] != 3'd0) stray++;
    prev_en = tx_en;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_unit(input logic [7:0] b, input int k, input bit s);
    if (s) return int'(b[k]);
    return (k == 0) ? int'(b[3:0]) : int'(b[7:4]);
  endfunction

  task automatic clear_mon();
    cap_n = 0; segs = 0; rdy_hi = 0; stray = 0;
  endtask

  task automatic do_reset(input bit s);
    rst_n = 1'b0;
    in_valid = 1'b0;
    ser_mode = s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic push(input logic [7:0] b, input bit sof, input bit eof);
    bit acc;
    in_valid = 1'b1; in_data = b; in_sof = sof; in_eof = eof;
    do begin
      @(negedge clk); #3; acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_frame(input int n, input bit hold_eof);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = fb[i]; in_sof = (i == 0); in_eof = hold_eof && (i == n-1);
      begin
        bit acc;
        do begin
          @(negedge clk); #3; acc = in_ready;
          @(posedge clk); #1;
        end while (!acc);
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic compare_frame(input int n, input string req);
    int upb = ser_mode ? 8 : 2;
    int bad = 0;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < upb; k++)
        if (i*upb + k < cap_n && cap[i*upb + k] != exp_unit(fb[i], k, ser_mode)) bad++;
    check(bad == 0, req, bad, 0);
    check(cap_n == n*upb, "R6", cap_n, n*upb);
    check(segs == 1, "R4", segs, 1);
    check(stray == 0, "R3", stray, 0);
  endtask

  task automatic edge_probe(input bit s);
    do_reset(s);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 8'hA5; in_sof = 1'b1; in_eof = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    #1;
    if (!s) begin
      check(tx_en == 1'b1, "R1", int'(tx_en), 1);
      check(tx_d == 4'h5, "R1", int'(tx_d), 5);
    end else begin
      check(tx_en == 1'b0, "R2", int'(tx_en), 0);
      @(negedge clk); #2;
      check(tx_en == 1'b1, "R2", int'(tx_en), 1);
      check(tx_d == 4'h1, "R2", int'(tx_d), 1);
    end
    repeat (12) @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R8 reset state
    do_reset(1'b0);
    #2;
    check(tx_en == 1'b0, "R8", int'(tx_en), 0);
    check(tx_d == 4'd0, "R8", int'(tx_d), 0);
    check(in_ready == 1'b1, "R8", int'(in_ready), 1);

    // R1 / R2 launch edges
    edge_probe(1'b0);
    edge_probe(1'b1);

    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      @(posedge clk); #1;
      // directed one-byte frame
      fb[0] = 8'h3C;
      clear_mon();
      send_frame(1, 1'b1);
      repeat (12) @(posedge clk); #1;
      compare_frame(1, m ? "R2" : "R1");
      check(rdy_hi == 0, "R4", rdy_hi, 0);

      // R5 drop without start marker
      clear_mon();
      push(8'hFF, 1'b0, 1'b0);
      repeat (12) @(posedge clk); #1;
      check(cap_n == 0, "R5", cap_n, 0);

      // random frames
      for (int f = 0; f < 12; f++) begin
        int n = 1 + int'($urandom_range(15));
        for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
        clear_mon();
        send_frame(n, 1'b1);
        repeat (12 + int'($urandom_range(4))) @(posedge clk); #1;
        compare_frame(n, m ? "R2" : "R1");
        check(rdy_hi == n - 1, "R4", rdy_hi, n - 1);
      end

      // R7 underrun after two bytes
      fb[0] = 8'h96; fb[1] = 8'h1E;
      clear_mon();
      send_frame(2, 1'b0);
      repeat (12) @(posedge clk); #1;
      compare_frame(2, "R7");
      clear_mon();
      push(8'h77, 1'b0, 1'b1);
      repeat (12) @(posedge clk); #1;
      check(cap_n == 0, "R7", cap_n, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule